// File: doc/BRIEF.md
# Aging Counter LRU Approximator

This block tracks how recently each physical page frame has been used and names a frame to evict when asked. Every frame owns a small aging counter and a single "touched" flag. A memory reference to a frame raises its flag. A periodic interval pulse shifts every counter one place toward its least significant bit and feeds the frame's flag into the vacated top bit, after which all flags drop. A frame that has been touched in recent intervals therefore holds a large counter, and an idle frame decays toward zero.

When the replacement logic raises a request, the block scans all counters in one combinational pass, picks the frame holding the smallest value (lowest index on a tie) and presents that frame and its counter value on registered outputs one cycle later. When a fresh page is loaded into a frame, a per-frame wipe input restarts that frame's history from zero. The source of the interval pulse, the eviction itself and any page-table state lie outside the block.

Top module: `aging_lru`

## Requirements
- R1: After `rst` is held high for one clock edge, every counter and every touched flag is zero and `victim_valid` is 0; a request then returns frame 0 with age 0.
- R2: A reference (`ref_valid` high, frame `ref_frame`) raises that frame's touched flag; it shows up at the next interval pulse as bit 7 (value 0x80) of the frame's counter.
- R3: On an interval pulse (`tick` high) each counter becomes its old value shifted right by one bit, with the frame's touched flag entering the most significant bit.
- R4: After an interval pulse all touched flags are zero, so a frame not referenced during the next interval receives 0 in its top bit at the following pulse.
- R5: The victim is the frame whose counter holds the smallest value, and `victim_age` carries that counter value.
- R6: When several frames share the smallest value, the one with the lowest index is chosen.
- R7: A reference arriving in the same cycle as an interval pulse does not enter the counter at that pulse; it is kept as the touched flag and enters the counter at the next pulse.
- R8: A wipe (`clr_valid` high, frame `clr_frame`) zeroes that frame's counter and touched flag; it takes precedence over a same-cycle reference or interval pulse for that frame.
- R9: A request sampled at a clock edge produces `victim_valid` high for exactly the following cycle, with `victim_frame`/`victim_age` computed from the counters as they stood before that edge (a same-cycle pulse or wipe is not yet seen); without a request `victim_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | A reference to a frame occurs this cycle |
| ref_frame | input | 3 | Index of the referenced frame |
| tick | input | 1 | Interval pulse that ages all counters |
| clr_valid | input | 1 | Wipe the history of one frame |
| clr_frame | input | 3 | Index of the frame to wipe |
| victim_req | input | 1 | Request a replacement candidate |
| victim_valid | output | 1 | Victim outputs are valid this cycle |
| victim_frame | output | 3 | Index of the frame with the smallest counter |
| victim_age | output | 8 | Counter value of the chosen frame |

## Verification
Every input takes effect at the first rising edge after it is driven: a reference moves a flag at that edge but reaches a counter only at the next interval pulse, and a request produces its victim on the outputs directly after the edge that samples it, built from the counter values held before that edge. The bench drives inputs on the falling edge and compares outputs at the following falling edge, so each comparison sits one edge after its stimulus; where a request shares a cycle with a pulse or wipe, the expected value is the pre-edge state, and the effect of the pulse is checked by a later request. Touched flags, which are not outputs, are checked through the counter value they produce at a subsequent pulse.

// File: rtl/lru_age_pkg.sv
package lru_age_pkg;

    localparam int unsigned DEF_FRAMES = 8;
    localparam int unsigned DEF_AGE_W  = 8;

    // Per-frame control presented by the top to each frame unit
    typedef struct packed {
        logic hit;    // frame referenced this cycle
        logic tick;   // interval pulse
        logic wipe;   // restart this frame's history
    } frame_ctl_t;

    // What a frame does with its counter at the next edge
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_AGE  = 2'd1,
        ACT_WIPE = 2'd2
    } age_act_t;

    function automatic age_act_t pick_action(frame_ctl_t c);
        if (c.wipe)      return ACT_WIPE;
        else if (c.tick) return ACT_AGE;
        else             return ACT_HOLD;
    endfunction

endpackage

// File: rtl/age_frame.sv
module age_frame
    import lru_age_pkg::*;
#(
    parameter int unsigned AGE_W = DEF_AGE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  frame_ctl_t       ctl,
    output logic [AGE_W-1:0] age,
    output logic             touched
);

    age_act_t act;

    always_comb act = pick_action(ctl);

    always_ff @(posedge clk) begin
        if (rst) begin
            age     <= '0;
            touched <= 1'b0;
        end else begin
            unique case (act)
                ACT_WIPE: begin
                    age     <= '0;
                    touched <= 1'b0;
                end
                ACT_AGE: begin
                    age     <= {touched, age[AGE_W-1:1]};
                    touched <= ctl.hit;
                end
                default: begin
                    touched <= touched | ctl.hit;
                end
            endcase
        end
    end

    // R3: pulse shifts right and loads the flag on top
    a_r3_shift: assert property (@(posedge clk) disable iff (rst)
        (ctl.tick && !ctl.wipe) |=> (age == {$past(touched), $past(age[AGE_W-1:1])}));

    // R2: a reference raises the flag
    a_r2_ref_sets: assert property (@(posedge clk) disable iff (rst)
        (ctl.hit && !ctl.wipe) |=> touched);

    // R4: flags drop after a pulse without a new reference
    a_r4_flag_drops: assert property (@(posedge clk) disable iff (rst)
        (ctl.tick && !ctl.hit && !ctl.wipe) |=> !touched);

    // R7: same-cycle reference survives the pulse, top bit from old flag
    a_r7_ref_held: assert property (@(posedge clk) disable iff (rst)
        (ctl.tick && ctl.hit && !ctl.wipe && !touched) |=> (touched && !age[AGE_W-1]));

    // R8: wipe wins
    a_r8_wipe: assert property (@(posedge clk) disable iff (rst)
        ctl.wipe |=> (age == '0 && !touched));

    // Counters only move on a pulse or wipe
    a_r3_stable: assert property (@(posedge clk) disable iff (rst)
        (!ctl.tick && !ctl.wipe) |=> $stable(age));

endmodule

// File: rtl/victim_search.sv
module victim_search #(
    parameter int unsigned N_FRAMES = 8,
    parameter int unsigned AGE_W    = 8,
    localparam int unsigned IDX_W   = (N_FRAMES > 1) ? $clog2(N_FRAMES) : 1
) (
    input  logic [N_FRAMES-1:0][AGE_W-1:0] ages,
    output logic [IDX_W-1:0]               best_idx,
    output logic [AGE_W-1:0]               best_age
);

    // Linear scan with strict less-than keeps the lowest index on ties
    always_comb begin
        best_idx = '0;
        best_age = ages[0];
        for (int i = 1; i < N_FRAMES; i++) begin
            if (ages[i] < best_age) begin
                best_idx = IDX_W'(i);
                best_age = ages[i];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N_FRAMES; i++) begin
            // R5: nothing is smaller than the chosen value
            a_r5_is_min: assert (ages[i] >= best_age);
            // R6: no lower index carries the same value
            if (IDX_W'(i) < best_idx) begin
                a_r6_lowest_idx: assert (ages[i] != best_age);
            end
        end
    end

endmodule

// File: rtl/aging_lru.sv
module aging_lru
    import lru_age_pkg::*;
#(
    parameter int unsigned NUM_FRAMES = DEF_FRAMES,
    parameter int unsigned AGE_W      = DEF_AGE_W,
    localparam int unsigned IDX_W     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_valid,
    input  logic [IDX_W-1:0] ref_frame,
    input  logic             tick,
    input  logic             clr_valid,
    input  logic [IDX_W-1:0] clr_frame,
    input  logic             victim_req,
    output logic             victim_valid,
    output logic [IDX_W-1:0] victim_frame,
    output logic [AGE_W-1:0] victim_age
);

    logic [NUM_FRAMES-1:0][AGE_W-1:0] ages;
    logic [NUM_FRAMES-1:0]            flags;
    frame_ctl_t                       ctl [NUM_FRAMES];
    logic [IDX_W-1:0]                 pick_idx;
    logic [AGE_W-1:0]                 pick_age;

    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
        always_comb begin
            ctl[g].hit  = ref_valid && (ref_frame == IDX_W'(g));
            ctl[g].tick = tick;
            ctl[g].wipe = clr_valid && (clr_frame == IDX_W'(g));
        end

        age_frame #(.AGE_W(AGE_W)) u_frame (
            .clk     (clk),
            .rst     (rst),
            .ctl     (ctl[g]),
            .age     (ages[g]),
            .touched (flags[g])
        );
    end

    victim_search #(.N_FRAMES(NUM_FRAMES), .AGE_W(AGE_W)) u_search (
        .ages     (ages),
        .best_idx (pick_idx),
        .best_age (pick_age)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            victim_valid <= 1'b0;
            victim_frame <= '0;
            victim_age   <= '0;
        end else begin
            victim_valid <= victim_req;
            if (victim_req) begin
                victim_frame <= pick_idx;
                victim_age   <= pick_age;
            end
        end
    end

    // R9: one-cycle result after each request
    a_r9_valid_after_req: assert property (@(posedge clk) disable iff (rst)
        victim_req |=> victim_valid);

    a_r9_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !victim_req |=> !victim_valid);

    // R1: flags are clear right after reset
    a_r1_flags_clear: assert property (@(posedge clk)
        $past(rst) |-> (flags == '0 && !victim_valid));

endmodule

// File: tb/aging_lru_test.sv
`timescale 1ns/100ps
module aging_lru_test;

    typedef struct packed {
        logic       rv;
        logic [2:0] rf;
        logic       tk;
        logic       cv;
        logic [2:0] cf;
        logic       rq;
        logic [2:0] ef;
        logic [7:0] ea;
    } step_t;

    localparam int NSTEP = 22;
    // rv rf tk cv cf rq | expected frame, age (used when rq)
    localparam step_t VEC [NSTEP] = '{
        '{1'b1, 3'd2, 1'b0, 1'b0, 3'd0, 1'b1, 3'd0, 8'h00}, // 0  R1 all zero -> f0
        '{1'b1, 3'd5, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00}, // 1
        '{1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 1'b1, 3'd0, 8'h00}, // 2  R9 pre-pulse view
        '{1'b1, 3'd0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd0, 8'h00}, // 3  R5/R6 f0 still zero
        '{1'b1, 3'd1, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00}, // 4
        '{1'b1, 3'd3, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00}, // 5
        '{1'b1, 3'd4, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00}, // 6
        '{1'b1, 3'd6, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00}, // 7
        '{1'b1, 3'd7, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00}, // 8  R7 ref with pulse
        '{1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd7, 8'h00}, // 9  R7 f7 not aged in
        '{1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00}, // 10 R3 pulse
        '{1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd2, 8'h20}, // 11 R6 tie f2/f5
        '{1'b1, 3'd2, 1'b0, 1'b1, 3'd2, 1'b1, 3'd2, 8'h20}, // 12 R8 wipe+ref
        '{1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 1'b1, 3'd2, 8'h00}, // 13 R8 wiped value
        '{1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd2, 8'h00}, // 14 R8 flag wiped
        '{1'b0, 3'd0, 1'b1, 1'b1, 3'd7, 1'b0, 3'd0, 8'h00}, // 15 R8 wipe+pulse
        '{1'b1, 3'd2, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00}, // 16
        '{1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00}, // 17
        '{1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd7, 8'h00}, // 18 R8 f7 zeroed
        '{1'b1, 3'd7, 1'b0, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00}, // 19
        '{1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00}, // 20
        '{1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b1, 3'd5, 8'h02}  // 21 R3/R5 f5 decayed
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       ref_valid, tick, clr_valid, victim_req;
    logic [2:0] ref_frame, clr_frame;
    logic       victim_valid;
    logic [2:0] victim_frame;
    logic [7:0] victim_age;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    aging_lru uut (
        .clk(clk), .rst(rst),
        .ref_valid(ref_valid), .ref_frame(ref_frame),
        .tick(tick),
        .clr_valid(clr_valid), .clr_frame(clr_frame),
        .victim_req(victim_req),
        .victim_valid(victim_valid), .victim_frame(victim_frame),
        .victim_age(victim_age)
    );

    task automatic check(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Drive one cycle of stimulus (called at a falling edge), then wait a full cycle
    task automatic step(input logic rv, input logic [2:0] rf, input logic tk,
                        input logic cv, input logic [2:0] cf, input logic rq);
        ref_valid = rv; ref_frame = rf; tick = tk;
        clr_valid = cv; clr_frame = cf; victim_req = rq;
        @(negedge clk);
        ref_valid = 1'b0; tick = 1'b0; clr_valid = 1'b0; victim_req = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic expect_victim(input logic [2:0] f, input logic [7:0] a, input string tag);
        check(int'(victim_valid), 1, {tag, " valid"});
        check(int'(victim_frame), int'(f), {tag, " frame"});
        check(int'(victim_age), int'(a), {tag, " age"});
    endtask

    initial begin
        rst = 1'b1; ref_valid = 1'b0; ref_frame = '0; tick = 1'b0;
        clr_valid = 1'b0; clr_frame = '0; victim_req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(int'(victim_valid), 0, "R1 valid low after reset");

        // Table walk
        for (int k = 0; k < NSTEP; k++) begin
            step(VEC[k].rv, VEC[k].rf, VEC[k].tk, VEC[k].cv, VEC[k].cf, VEC[k].rq);
            if (VEC[k].rq)
                expect_victim(VEC[k].ef, VEC[k].ea, $sformatf("table step %0d", k));
            else
                check(int'(victim_valid), 0, $sformatf("R9 no request step %0d", k));
        end

        // R1: reset in mid-run restores all-zero state
        do_reset();
        check(int'(victim_valid), 0, "R1 valid low after mid-run reset");
        step(1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b1);
        expect_victim(3'd0, 8'h00, "R1 post-reset victim");

        // R4: flags drop after a pulse; f3 skipped in the second interval
        for (int f = 0; f < 8; f++) step(1'b1, 3'(f), 1'b0, 1'b0, 3'd0, 1'b0);
        step(1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 1'b0);
        for (int f = 0; f < 8; f++)
            if (f != 3) step(1'b1, 3'(f), 1'b0, 1'b0, 3'd0, 1'b0);
        step(1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 1'b0);
        step(1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b1);
        expect_victim(3'd3, 8'h40, "R4 unreferenced frame gets 0 on top");

        // R2/R3: f3 referenced, two pulses: 0x40 -> 0xA0 -> 0x50; others C0 -> 60 -> 30
        step(1'b1, 3'd3, 1'b0, 1'b0, 3'd0, 1'b0);
        step(1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 1'b0);
        step(1'b0, 3'd0, 1'b1, 1'b0, 3'd0, 1'b0);
        step(1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b1);
        expect_victim(3'd0, 8'h30, "R2 R3 aging with a reference");

        // R9: result is a single-cycle pulse
        @(negedge clk);
        check(int'(victim_valid), 0, "R9 valid drops after one cycle");

        // R8: wipe alone brings frame to zero and it becomes the victim
        step(1'b0, 3'd0, 1'b0, 1'b1, 3'd6, 1'b0);
        step(1'b0, 3'd0, 1'b0, 1'b0, 3'd0, 1'b1);
        expect_victim(3'd6, 8'h00, "R8 wiped frame is victim");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule